// File: doc/BRIEF.md
# Daisy-Chain SPI Write Command Parser

This block sits behind the byte deserialiser of an SPI slave on one chip of a daisy chain. It reads the received byte stream and turns write commands into 32-bit word writes on an internal address space. A frame may carry several write commands. A break byte restarts chain addressing. Each skip byte that follows the break moves the target one chip further down the chain. This chip acts on a write only when the number of skips seen equals its own chain position, which is a parameter. A write whose skip count does not match is still parsed through to its end, but it produces no write strobe.

A write command is a header byte that carries the word count, then a two-byte address, then four payload bytes for each word. Payload bytes arrive on the wire with their bit order mirrored, and the block restores the order before it assembles each word. A small bank of configuration flags watches the block's own write port. Each flag has a fixed address and is set only when one exact 32-bit arming value is written to that address. Any other value written there clears it.

Top module: `chain_cmd_parser`

## Requirements
- R1: After reset `wr_en` is 0 and every bit of `cfg_en` is 0.
- R2: While idle, a byte whose top three bits are 111 is a write header. Its low five bits hold the word count minus one. The next two bytes are the start address, high byte first.
- R3: Each payload byte is bit-mirrored before use (wire bit 0 becomes data bit 7). The four restored bytes of a word are packed with the first byte in bits 7:0 and the fourth byte in bits 31:24.
- R4: Word k of a burst (k = 0..count-1) is written to start address + k. `wr_en` is high for exactly one cycle, the cycle after the edge that takes the fourth byte of the word.
- R5: While idle, byte 0x05 adds one to the skip count, which saturates. A header seen while the skip count differs from CHAIN_POS is consumed with its address and payload but causes no write, and the parser is idle again after its last payload byte.
- R6: While idle, byte 0x04 clears the skip count. Inside the address or payload, 0x04 and 0x05 are ordinary data.
- R7: While `cs_n` is high the parser returns to idle, clears the skip count and drops any partly received word without a write. `wr_en` is 0 in the cycle after any cycle with `cs_n` high.
- R8: While idle, a byte that is not 0x04, not 0x05 and not a header is ignored.
- R9: Flag n of `cfg_en` (address CFG_BASE + 32·n, default 0x7000 + 32·n) changes only in the cycle after a write to its address. It becomes 1 if the written word is 0xE3596AC1 (restored bytes C1, 6A, 59, E3 in arrival order) and 0 for any other word. Writes to other addresses leave all flags unchanged.
- R10: A header with count field 31 produces 32 writes at consecutive addresses, and the next header is parsed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high ends the frame |
| rx_valid | input | 1 | One received byte is present this cycle |
| rx_byte | input | 8 | Received byte, as on the wire |
| wr_en | output | 1 | Word write strobe, one cycle per word |
| wr_addr | output | 16 | Word address of the write |
| wr_data | output | 32 | Restored, assembled word |
| cfg_en | output | NUM_CFG | Configuration flags, one per register |

## Verification
A wrong internal state shows up at the write port one word later at most. A byte counter that is off by one moves every following word by a byte, so a known pattern comes out rotated at the next strobe. A lost idle state makes a later header count as payload, so the expected writes go missing or land at the wrong addresses. A wrong skip count turns this chip's writes into silent ones, or makes another chip's burst appear, as soon as the next header arrives. A flag decode error shows in `cfg_en` one cycle after the offending write.

// File: rtl/chain_cmd_pkg.sv
// Shared constants, state type and helpers for the chained command parser.
// Assumes byte-wide input and a fixed 16-bit address, 32-bit word format.
package chain_cmd_pkg;
    localparam int ADDR_W = 16;
    localparam int WORD_W = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int IDX_W = $clog2(BYTES_PER_WORD);
    localparam int CNT_W = 5;

    localparam logic [7:0] BYTE_BREAK = 8'h04;
    localparam logic [7:0] BYTE_SKIP  = 8'h05;
    localparam logic [2:0] HDR_TAG    = 3'b111;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_ADDR_HI,
        PS_ADDR_LO,
        PS_DATA
    } parse_state_e;

    // Mirror the bit order of one byte.
    function automatic logic [7:0] flip8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction
endpackage

// File: rtl/ccp_chain_filter.sv
// Skip counter for daisy-chain addressing. It counts skip events since the
// last clear and flags when the count equals this chip's chain position.
// Assumes clear and step are never both relevant in one cycle (clear wins).
module ccp_chain_filter #(
    parameter int CHAIN_POS = 0,
    parameter int CHAIN_MAX = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic selected
);
    localparam int SKIP_W = $clog2(CHAIN_MAX + 1);
    localparam logic [SKIP_W-1:0] POS_V = SKIP_W'(CHAIN_POS);
    localparam logic [SKIP_W-1:0] MAX_V = SKIP_W'(CHAIN_MAX);

    logic [SKIP_W-1:0] skip_cnt;

    // Count skips, saturate at the top, clear on break or deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)                       skip_cnt <= '0;
        else if (clear)                   skip_cnt <= '0;
        else if (step && skip_cnt != MAX_V) skip_cnt <= skip_cnt + 1'b1;
    end

    assign selected = (skip_cnt == POS_V);
endmodule

// File: rtl/ccp_burst_fsm.sv
// Frame parser: recognises break, skip and header bytes while idle, takes
// the address, restores and packs payload bytes, and issues word writes.
// Assumes one byte per rx_valid cycle; cs_n high overrides everything.
module ccp_burst_fsm
    import chain_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              selected,
    output logic              chain_clear,
    output logic              chain_step,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES_PER_WORD - 1);

    parse_state_e      state;
    logic              mine;
    logic [CNT_W-1:0]  words_left;
    logic [IDX_W-1:0]  byte_idx;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] acc_nxt;
    logic              idle_byte;

    assign idle_byte = !cs_n && rx_valid && (state == PS_IDLE);

    // Chain events are only decoded between commands.
    always_comb begin
        chain_clear = cs_n || (idle_byte && rx_byte == BYTE_BREAK);
        chain_step  = idle_byte && rx_byte == BYTE_SKIP;
    end

    // Merge the restored byte into its slot of the word being built.
    always_comb begin
        acc_nxt = acc;
        acc_nxt[8*byte_idx +: 8] = flip8(rx_byte);
    end

    // Main parse sequence and write port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PS_IDLE;
            mine       <= 1'b0;
            words_left <= '0;
            byte_idx   <= '0;
            cur_addr   <= '0;
            acc        <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (cs_n) begin
                state    <= PS_IDLE;
                byte_idx <= '0;
            end else if (rx_valid) begin
                case (state)
                    PS_IDLE: begin
                        if (rx_byte[7:5] == HDR_TAG) begin
                            mine       <= selected;
                            words_left <= rx_byte[CNT_W-1:0];
                            state      <= PS_ADDR_HI;
                        end
                    end
                    PS_ADDR_HI: begin
                        cur_addr[15:8] <= rx_byte;
                        state          <= PS_ADDR_LO;
                    end
                    PS_ADDR_LO: begin
                        cur_addr[7:0] <= rx_byte;
                        byte_idx      <= '0;
                        state         <= PS_DATA;
                    end
                    PS_DATA: begin
                        acc <= acc_nxt;
                        if (byte_idx == LAST_IDX) begin
                            wr_en    <= mine;
                            wr_addr  <= cur_addr;
                            wr_data  <= acc_nxt;
                            cur_addr <= cur_addr + 1'b1;
                            byte_idx <= '0;
                            if (words_left == '0) state <= PS_IDLE;
                            else                  words_left <= words_left - 1'b1;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                        end
                    end
                    default: state <= PS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ccp_cfg_bank.sv
// Configuration flags armed by an exact value. Each flag snoops the word
// write port and updates on a write to its own address.
// Assumes flag addresses are distinct within the 16-bit space.
module ccp_cfg_bank
    import chain_cmd_pkg::*;
#(
    parameter int          NUM_CFG    = 12,
    parameter int          CFG_BASE   = 32'h7000,
    parameter int          CFG_STRIDE = 32,
    parameter logic [31:0] MAGIC      = 32'hE3596AC1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [NUM_CFG-1:0] cfg_en
);
    logic value_ok;
    assign value_ok = (wr_data == MAGIC);

    for (genvar n = 0; n < NUM_CFG; n++) begin : g_flag
        localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(CFG_BASE + CFG_STRIDE * n);
        // Arm or disarm this flag on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)                           cfg_en[n] <= 1'b0;
            else if (wr_en && wr_addr == FLAG_ADDR) cfg_en[n] <= value_ok;
        end
    end
endmodule

// File: rtl/chain_cmd_parser.sv
// Top of the chained SPI command parser: chain filter, frame parser and
// configuration flags. Assumes a byte stream from an SPI slave deserialiser.
module chain_cmd_parser #(
    parameter int          CHAIN_POS  = 0,
    parameter int          CHAIN_MAX  = 15,
    parameter int          NUM_CFG    = 12,
    parameter int          CFG_BASE   = 32'h7000,
    parameter int          CFG_STRIDE = 32,
    parameter logic [31:0] MAGIC      = 32'hE3596AC1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    output logic               wr_en,
    output logic [15:0]        wr_addr,
    output logic [31:0]        wr_data,
    output logic [NUM_CFG-1:0] cfg_en
);
    logic selected;
    logic chain_clear;
    logic chain_step;

    ccp_chain_filter #(
        .CHAIN_POS(CHAIN_POS),
        .CHAIN_MAX(CHAIN_MAX)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (chain_clear),
        .step    (chain_step),
        .selected(selected)
    );

    ccp_burst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .selected   (selected),
        .chain_clear(chain_clear),
        .chain_step (chain_step),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    ccp_cfg_bank #(
        .NUM_CFG   (NUM_CFG),
        .CFG_BASE  (CFG_BASE),
        .CFG_STRIDE(CFG_STRIDE),
        .MAGIC     (MAGIC)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cfg_en (cfg_en)
    );
endmodule

// File: rtl/ccp_checker.sv
// Port-level properties of the chained command parser, bound to the top.
module ccp_checker #(
    parameter int          NUM_CFG  = 12,
    parameter int          CFG_BASE = 32'h7000,
    parameter logic [31:0] MAGIC    = 32'hE3596AC1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               wr_en,
    input logic [15:0]        wr_addr,
    input logic [31:0]        wr_data,
    input logic [NUM_CFG-1:0] cfg_en
);
    // R4: a word strobe lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R7: no write follows a deselected cycle
    a_r7_cs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !wr_en);

    // R9: flags move only after a write
    a_r9_cfg_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_en) |-> $past(wr_en));

    // R9: flag 0 follows the arming value written to its address
    a_r9_cfg_value: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_addr) == 16'(CFG_BASE))
            |-> (cfg_en[0] == ($past(wr_data) == MAGIC)));
endmodule

bind chain_cmd_parser ccp_checker #(
    .NUM_CFG (NUM_CFG),
    .CFG_BASE(CFG_BASE),
    .MAGIC   (MAGIC)
) u_ccp_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .cfg_en (cfg_en)
);

// File: tb/test_chain_cmd_parser.sv
module test_chain_cmd_parser;
    localparam int CLK_P = 10;
    localparam int NCFG = 12;
    localparam logic [31:0] ARM = 32'hE3596AC1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [NCFG-1:0] cfg_en;

    int total = 0;
    int bad = 0;
    int nlog = 0;
    logic [15:0] log_addr [0:255];
    logic [31:0] log_data [0:255];

    chain_cmd_parser i_chain_cmd_parser (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_en(cfg_en)
    );

    always #(CLK_P/2) clk = ~clk;

    // record every write strobe away from the edge
    always @(negedge clk) begin
        if (wr_en && nlog < 256) begin
            log_addr[nlog] = wr_addr;
            log_data[nlog] = wr_data;
            nlog = nlog + 1;
        end
    end

    function automatic logic [7:0] mirror(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte = b;
    endtask

    task automatic settle(input int n);
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic put_hdr(input int nwords, input logic [15:0] a);
        put(8'hE0 | 8'(nwords - 1));
        put(a[15:8]);
        put(a[7:0]);
    endtask

    task automatic put_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) put(mirror(w[8*i +: 8]));
    endtask

    task automatic expect_wr(input int idx, input logic [15:0] a, input logic [31:0] d, input string req);
        chk(idx < nlog, req, 64'(nlog), 64'(idx + 1));
        if (idx < nlog) begin
            chk(log_addr[idx] == a, req, 64'(log_addr[idx]), 64'(a));
            chk(log_data[idx] == d, req, 64'(log_data[idx]), 64'(d));
        end
    endtask

    task automatic deselect();
        @(negedge clk);
        rx_valid = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic t_reset();
        chk(wr_en == 1'b0, "R1 wr_en", 64'(wr_en), 0);
        chk(cfg_en == '0, "R1 cfg_en", 64'(cfg_en), 0);
    endtask

    task automatic t_single();
        int s = nlog;
        put(8'h04);
        put_hdr(1, 16'h1234);
        put_word(32'hA1B2C3D4);
        settle(2);
        chk(nlog == s + 1, "R2 one write", 64'(nlog - s), 1);
        expect_wr(s, 16'h1234, 32'hA1B2C3D4, "R3 restored word");
    endtask

    task automatic t_burst();
        int s = nlog;
        put_hdr(3, 16'h0100);
        put_word(32'h11111111);
        put_word(32'h2222_5555);
        put_word(32'h0F0E0D0C);
        settle(2);
        chk(nlog == s + 3, "R4 burst count", 64'(nlog - s), 3);
        expect_wr(s, 16'h0100, 32'h11111111, "R4 word0");
        expect_wr(s + 1, 16'h0101, 32'h22225555, "R4 word1");
        expect_wr(s + 2, 16'h0102, 32'h0F0E0D0C, "R4 word2");
    endtask

    task automatic t_break_in_data();
        int s = nlog;
        put_hdr(1, 16'h0405);
        put(8'h04); put(8'h05); put(8'hFF); put(8'hE1);
        settle(2);
        expect_wr(s, 16'h0405, 32'h87FFA020, "R6 break byte as data");
    endtask

    task automatic t_chain();
        int s = nlog;
        put(8'h04);
        put(8'h05);
        put_hdr(1, 16'h0200);
        put_word(32'hDEADBEEF);
        put_hdr(2, 16'h0300);
        put_word(32'h1);
        put_word(32'h2);
        settle(2);
        chk(nlog == s, "R5 foreign bursts silent", 64'(nlog - s), 0);
        put(8'h04);
        put_hdr(1, 16'h0210);
        put_word(32'hCAFEF00D);
        settle(2);
        expect_wr(s, 16'h0210, 32'hCAFEF00D, "R6 break restores selection");
    endtask

    task automatic t_junk();
        int s = nlog;
        put(8'h00); put(8'h12); put(8'hC0); put(8'h80); put(8'h3F);
        settle(2);
        chk(nlog == s, "R8 junk silent", 64'(nlog - s), 0);
        put_hdr(1, 16'h0555);
        put_word(32'h01234567);
        settle(2);
        expect_wr(s, 16'h0555, 32'h01234567, "R8 header after junk");
    endtask

    task automatic t_cs_abort();
        int s = nlog;
        put_hdr(1, 16'h0600);
        put(8'h12); put(8'h34);
        deselect();
        repeat (2) @(negedge clk);
        chk(nlog == s, "R7 partial word dropped", 64'(nlog - s), 0);
        put_hdr(1, 16'h0601);
        put_word(32'h89ABCDEF);
        settle(2);
        chk(nlog == s + 1, "R7 one write after reselect", 64'(nlog - s), 1);
        expect_wr(s, 16'h0601, 32'h89ABCDEF, "R7 fresh word");
        put(8'h05);
        settle(0);
        deselect();
        put_hdr(1, 16'h0602);
        put_word(32'h5A5A5A5A);
        settle(2);
        expect_wr(s + 1, 16'h0602, 32'h5A5A5A5A, "R7 skip count cleared");
    endtask

    task automatic t_cfg();
        put_hdr(1, 16'h7060);
        put_word(ARM);
        settle(3);
        chk(cfg_en == 12'h008, "R9 arm flag3", 64'(cfg_en), 64'h008);
        put_hdr(1, 16'h7061);
        put_word(ARM);
        settle(3);
        chk(cfg_en == 12'h008, "R9 off-grid address", 64'(cfg_en), 64'h008);
        put_hdr(2, 16'h7000);
        put_word(ARM);
        put_word(ARM);
        settle(3);
        chk(cfg_en == 12'h009, "R9 burst arms flag0 only", 64'(cfg_en), 64'h009);
        put_hdr(1, 16'h7060);
        put_word(32'hE3596AC0);
        settle(3);
        chk(cfg_en == 12'h001, "R9 near value disarms", 64'(cfg_en), 64'h001);
        put_hdr(1, 16'h7160);
        put_word(ARM);
        settle(3);
        chk(cfg_en == 12'h801, "R9 last flag", 64'(cfg_en), 64'h801);
    endtask

    task automatic t_max();
        int s = nlog;
        int ok = 1;
        put_hdr(32, 16'h2000);
        for (int k = 0; k < 32; k++) put_word(32'h0101_0101 * k + 32'h9);
        settle(2);
        chk(nlog == s + 32, "R10 32 writes", 64'(nlog - s), 32);
        for (int k = 0; k < 32; k++)
            if (s + k < nlog && (log_addr[s+k] != 16'(16'h2000 + k) ||
                                 log_data[s+k] != 32'h0101_0101 * k + 32'h9)) ok = 0;
        chk(ok == 1, "R10 addresses and data", 64'(ok), 1);
        put_hdr(1, 16'h2100);
        put_word(32'h77);
        settle(2);
        expect_wr(s + 32, 16'h2100, 32'h77, "R10 next header");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cs_n = 1'b0;
        @(negedge clk);
        t_single();
        t_burst();
        t_break_in_data();
        t_chain();
        t_junk();
        t_cs_abort();
        t_cfg();
        t_max();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule